// File: doc/BRIEF.md
# Pin-Selected Power Domain Controller

This block drives eight power-down enables for the analog and digital sections of a transceiver front end. Three 8-bit configuration registers are loaded through a small write port. Two of the registers hold power-down masks, and the level of a power-down pin picks which mask is applied. The outputs follow a pin change in the same cycle, with no clock edge in between.

A duplex strap selects between two operating modes. In full-duplex mode the selected mask is applied as it is. In half-duplex mode a third register adds further controls driven by the transmit-enable pin:

- The transmit sections power down a programmable number of clock cycles after transmit-enable falls.
- The receive sections can be tied to the transmit-enable level or held off.

The half-duplex requests are ORed with the selected mask. A separate amplifier-off output lets the transmit amplifier shut down while the DAC core stays powered.

The write port takes a valid/ready handshake. `cfg_ready` is held high, so the block never applies back-pressure. A write is accepted on any rising edge at which `cfg_valid` is high.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: After reset the low-pin mask reads 0x00, the high-pin mask reads 0x7F and the half-duplex control register reads 0x00. With the pin low every output is 0. With the pin high every domain except the PLL is powered down.
- R2: `pd_out` bit positions are: 7 PLL, 6 DAC/amplifier, 5 TX digital, 4 reference, 3 ADC common-mode, 2 ADC, 1 PGA bias, 0 RX PGA. A 1 powers that domain down.
- R3: `cfg_ready` is always 1. An accepted write goes to one register by address: 1 for the low-pin mask, 2 for the high-pin mask, 3 for the half-duplex control. The new value shows on the outputs from the cycle after the accepting edge. A write to address 0 changes nothing.
- R4: With `pwrdwn_pin` low the address-1 mask is applied, and with it high the address-2 mask is applied. The selection is combinational.
- R5: With `duplex_full` = 1 the half-duplex control register has no effect. `pd_out` equals the selected mask and `amp_off` equals `pd_out[6]`.
- R6: In half-duplex mode with control bit 1 set, the TX digital domain (bit 5) and `amp_off` assert once TXEN has been sampled low on D·2^DLY_SHIFT + 1 consecutive rising edges, where D is control bits 7:3. This path does not drive `pd_out[6]`.
- R7: A high TXEN releases the half-duplex TX power-down combinationally and restarts the delay at the next fall. After reset with TXEN low, the TX path counts as already off.
- R8: In half-duplex mode with control bit 0 set, the ADC (bit 2) and RX PGA (bit 0) domains are powered down. If control bit 2 is set this holds only while TXEN is high; if bit 2 is clear it holds at all times. With bit 0 clear neither takes effect.
- R9: Each output is the OR of the selected mask bit and any half-duplex request. The PLL, reference, ADC common-mode and PGA bias bits come from the mask alone.
- R10: `amp_off` is `pd_out[6]` ORed with the half-duplex TX power-down request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Register write request |
| cfg_ready | output | 1 | Write acceptance, always high |
| cfg_addr | input | ADDR_W | Register address |
| cfg_data | input | 8 | Register write data |
| pwrdwn_pin | input | 1 | Mask select pin |
| duplex_full | input | 1 | 1 = full-duplex, 0 = half-duplex |
| txen | input | 1 | Transmit enable |
| pd_out | output | 8 | Domain power-down enables |
| amp_off | output | 1 | Transmit amplifier power-down |

## Verification
The bench builds the block with DLY_SHIFT = 2 instead of the default 4. Each delay step is then four cycles, so the largest delay code expires within 125 cycles. This brings full countdowns, mid-count cancellation and delay codes rewritten during a countdown within reach of a few thousand random cycles. Directed cases pin down the exact expiry edge for codes 3 and 0.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int NDOM = 8;
  typedef logic [NDOM-1:0] dom_mask_t;

  localparam int PD_PLL     = 7;
  localparam int PD_DACAMP  = 6;
  localparam int PD_TXDIG   = 5;
  localparam int PD_REF     = 4;
  localparam int PD_ADCCM   = 3;
  localparam int PD_ADC     = 2;
  localparam int PD_PGABIAS = 1;
  localparam int PD_RXPGA   = 0;

  localparam int CTL_RX_EN    = 0;
  localparam int CTL_TX_EN    = 1;
  localparam int CTL_RX_TXEN  = 2;
  localparam int HDX_DLY_LSB  = 3;
  localparam int HDX_DLY_W    = 5;

  localparam int NREG = 3;
  localparam dom_mask_t RST_MASK_LO = 8'h00;
  localparam dom_mask_t RST_MASK_HI = 8'h7F;
  localparam dom_mask_t RST_HDX     = 8'h00;

  function automatic dom_mask_t reg_reset(int idx);
    case (idx)
      0:       return RST_MASK_LO;
      1:       return RST_MASK_HI;
      default: return RST_HDX;
    endcase
  endfunction
endpackage

// File: rtl/pdc_cfg_regs.sv
module pdc_cfg_regs
  import pdc_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  dom_mask_t         wr_data,
  output dom_mask_t         mask_lo,
  output dom_mask_t         mask_hi,
  output dom_mask_t         hdx_ctl
);
  dom_mask_t cfg_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    dom_mask_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= reg_reset(g);
      else if (wr_en && wr_addr == ADDR_W'(g + 1))
        q <= wr_data;
    end
    assign cfg_q[g] = q;
  end

  assign mask_lo = cfg_q[0];
  assign mask_hi = cfg_q[1];
  assign hdx_ctl = cfg_q[2];

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(1)) |=> mask_lo == $past(wr_data));

  assert_addr0_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0) |=> ($stable(mask_lo) && $stable(mask_hi) && $stable(hdx_ctl)));
endmodule

// File: rtl/pdc_txoff_timer.sv
module pdc_txoff_timer
  import pdc_pkg::*;
#(
  parameter int DLY_SHIFT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 txen,
  input  logic [HDX_DLY_W-1:0] dly_code,
  output logic                 tx_idle
);
  localparam int CNT_W = HDX_DLY_W + DLY_SHIFT;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             expired;

  assign limit = CNT_W'(dly_code) << DLY_SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expired <= 1'b1;
      cnt     <= '0;
    end else if (txen) begin
      expired <= 1'b0;
      cnt     <= '0;
    end else if (!expired) begin
      if (cnt >= limit) expired <= 1'b1;
      else              cnt     <= cnt + 1'b1;
    end
  end

  assign tx_idle = expired & ~txen;

  assert_cancel_only_by_txen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(expired) |-> $past(txen));

  assert_expiry_reached_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!txen && !expired && cnt >= limit) |=> expired);
endmodule

// File: rtl/pdc_combine.sv
module pdc_combine
  import pdc_pkg::*;
(
  input  dom_mask_t mask_lo,
  input  dom_mask_t mask_hi,
  input  dom_mask_t hdx_ctl,
  input  logic      pin_hi,
  input  logic      full_dup,
  input  logic      txen,
  input  logic      tx_idle,
  output dom_mask_t pd,
  output logic      amp_off
);
  dom_mask_t sel;
  dom_mask_t hdx_req;
  logic      tx_req;
  logic      rx_req;

  always_comb begin
    sel     = pin_hi ? mask_hi : mask_lo;
    tx_req  = !full_dup && hdx_ctl[CTL_TX_EN] && tx_idle;
    rx_req  = !full_dup && hdx_ctl[CTL_RX_EN] &&
              (hdx_ctl[CTL_RX_TXEN] ? txen : 1'b1);
    hdx_req = '0;
    hdx_req[PD_TXDIG]  = tx_req;
    hdx_req[PD_ADC]    = rx_req;
    hdx_req[PD_RXPGA]  = rx_req;
    pd      = sel | hdx_req;
    amp_off = sel[PD_DACAMP] | tx_req;
  end
endmodule

// File: rtl/pwr_domain_ctrl.sv
module pwr_domain_ctrl
  import pdc_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DLY_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_data,
  input  logic              pwrdwn_pin,
  input  logic              duplex_full,
  input  logic              txen,
  output logic [7:0]        pd_out,
  output logic              amp_off
);
  dom_mask_t mask_lo, mask_hi, hdx_ctl;
  logic      tx_idle;

  assign cfg_ready = 1'b1;

  pdc_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_valid & cfg_ready),
    .wr_addr (cfg_addr),
    .wr_data (cfg_data),
    .mask_lo (mask_lo),
    .mask_hi (mask_hi),
    .hdx_ctl (hdx_ctl)
  );

  pdc_txoff_timer #(.DLY_SHIFT(DLY_SHIFT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .txen     (txen),
    .dly_code (hdx_ctl[HDX_DLY_LSB +: HDX_DLY_W]),
    .tx_idle  (tx_idle)
  );

  pdc_combine u_comb (
    .mask_lo  (mask_lo),
    .mask_hi  (mask_hi),
    .hdx_ctl  (hdx_ctl),
    .pin_hi   (pwrdwn_pin),
    .full_dup (duplex_full),
    .txen     (txen),
    .tx_idle  (tx_idle),
    .pd       (pd_out),
    .amp_off  (amp_off)
  );

  assert_full_dup_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    duplex_full |-> pd_out == (pwrdwn_pin ? mask_hi : mask_lo));

  assert_pll_mask_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_out[PD_PLL] == (pwrdwn_pin ? mask_hi[PD_PLL] : mask_lo[PD_PLL]));

  assert_amp_follows_dac_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pd_out[PD_DACAMP] |-> amp_off);

  assert_hdx_tx_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!duplex_full && hdx_ctl[CTL_TX_EN] && tx_idle) |-> (pd_out[PD_TXDIG] && amp_off));
endmodule

// File: tb/pwr_domain_ctrl_tb_top.sv
module pwr_domain_ctrl_tb_top;
  localparam int SH = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_valid = 1'b0;
  logic       cfg_ready;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic       pwrdwn_pin = 1'b0;
  logic       duplex_full = 1'b0;
  logic       txen = 1'b0;
  logic [7:0] pd_out;
  logic       amp_off;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  logic [7:0] m_lo = 8'h00, m_hi = 8'h7F, m_ctl = 8'h00;
  bit         m_exp = 1'b1;
  int         m_run = 0;

  always #4 clk = ~clk;

  pwr_domain_ctrl #(.ADDR_W(2), .DLY_SHIFT(SH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .pwrdwn_pin(pwrdwn_pin),
    .duplex_full(duplex_full), .txen(txen), .pd_out(pd_out), .amp_off(amp_off)
  );

  function automatic bit m_txoff();
    return m_exp && !txen;
  endfunction

  function automatic logic [7:0] exp_pd();
    logic [7:0] v;
    v = pwrdwn_pin ? m_hi : m_lo;
    if (!duplex_full) begin
      if (m_ctl[1] && m_txoff()) v[5] = 1'b1;
      if (m_ctl[0] && (m_ctl[2] ? txen : 1'b1)) begin
        v[2] = 1'b1;
        v[0] = 1'b1;
      end
    end
    return v;
  endfunction

  function automatic logic exp_amp();
    logic [7:0] v;
    v = exp_pd();
    return v[6] | (!duplex_full && m_ctl[1] && m_txoff());
  endfunction

  task automatic chk(bit ok, string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_model(string tag);
    chk({amp_off, pd_out} === {exp_amp(), exp_pd()}, tag,
        {amp_off, pd_out}, {exp_amp(), exp_pd()});
  endtask

  task automatic check_val(string tag, logic [8:0] exp);
    chk({amp_off, pd_out} === exp, tag, {amp_off, pd_out}, exp);
  endtask

  task automatic model_edge();
    int lim;
    lim = int'(m_ctl[7:3]) << SH;
    if (txen) begin
      m_exp = 1'b0;
      m_run = 0;
    end else if (!m_exp) begin
      if (m_run >= lim) m_exp = 1'b1;
      else m_run++;
    end
    if (cfg_valid && cfg_ready) begin
      case (cfg_addr)
        2'd1: m_lo  = cfg_data;
        2'd2: m_hi  = cfg_data;
        2'd3: m_ctl = cfg_data;
        default: ;
      endcase
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    cfg_valid = 1'b1;
    cfg_addr  = a;
    cfg_data  = d;
    step();
    cfg_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();

    // R1: reset values seen through both pin levels
    check_val("R1 reset low-pin mask", 9'h000);
    chk(cfg_ready === 1'b1, "R3 ready high", {8'h0, cfg_ready}, 9'h001);
    pwrdwn_pin = 1'b1; #1;
    check_val("R1 R4 reset high-pin mask", 9'h17F);
    pwrdwn_pin = 1'b0;

    // R2 R3: exclusive TX-only / RX-only masks
    wr(2'd1, 8'h60);
    wr(2'd2, 8'h05);
    duplex_full = 1'b1; #1;
    check_val("R2 R3 low-pin mask 0x60", 9'h160);
    pwrdwn_pin = 1'b1; #1;
    check_val("R4 high-pin mask 0x05", 9'h005);

    // R3: address 0 ignored
    wr(2'd0, 8'hFF);
    check_val("R3 addr0 ignored high", 9'h005);
    pwrdwn_pin = 1'b0; #1;
    check_val("R3 addr0 ignored low", 9'h160);

    // R5: control register inert in full duplex
    wr(2'd3, 8'h07);
    txen = 1'b1; step();
    check_val("R5 full duplex ignores control", 9'h160);
    txen = 1'b0; repeat (3) step();
    check_val("R5 full duplex txen low", 9'h160);

    // R6: exact expiry edge, D=3 -> 12 cycles
    wr(2'd1, 8'h00);
    duplex_full = 1'b0;
    wr(2'd3, 8'h1A);
    txen = 1'b1; step();
    check_val("R7 txen high tx on", 9'h000);
    txen = 1'b0;
    repeat (12) step();
    check_val("R6 before expiry", 9'h000);
    step();
    check_val("R6 at expiry", 9'h120);
    txen = 1'b1; #1;
    check_val("R7 immediate power-up", 9'h000);
    step();
    txen = 1'b0;
    repeat (5) step();
    txen = 1'b1; step();
    txen = 1'b0;
    repeat (12) step();
    check_val("R7 restart after cancel", 9'h000);
    step();
    check_val("R7 expiry after restart", 9'h120);

    // R6: D=0 expires on first low edge
    wr(2'd3, 8'h02);
    txen = 1'b1; step();
    txen = 1'b0; step();
    check_val("R6 zero delay", 9'h120);

    // R8: receive controls
    wr(2'd3, 8'h05);
    txen = 1'b1; #1;
    check_val("R8 rx off while txen high", 9'h005);
    txen = 1'b0; #1;
    check_val("R8 rx on when txen low", 9'h000);
    wr(2'd3, 8'h01);
    check_val("R8 rx held off", 9'h005);
    wr(2'd3, 8'h04);
    txen = 1'b1; #1;
    check_val("R8 rx enable clear", 9'h000);

    // R9: OR of mask and half-duplex requests
    wr(2'd1, 8'h12);
    wr(2'd3, 8'h07);
    check_val("R9 or combine", 9'h017);
    txen = 1'b0;
    step();
    check_val("R9 R10 tx off plus mask", 9'h132);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 8 == 0)  pwrdwn_pin  = ~pwrdwn_pin;
      if ($urandom % 64 == 0) duplex_full = ~duplex_full;
      if ($urandom % 20 == 0) txen        = ~txen;
      cfg_valid = ($urandom % 16 == 0);
      cfg_addr  = 2'($urandom % 4);
      cfg_data  = 8'($urandom);
      step();
      check_model("R4 R6 R8 R9 R10 random");
    end
    cfg_valid = 1'b0;

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule